// File: doc/BRIEF.md
# Privileged Virtual Segment Decoder

This block sits in front of the translation lookaside buffer of a 32-bit processor. Each cycle it takes a virtual address, the current privilege mode, the error-level bit and the access direction. It sorts the address into one of five fixed address windows and then picks one of three routes. It can form a physical address directly with no table lookup. It can hand the request to the translation buffer. Or it can refuse the access as an address error.

When the translation buffer answers, the decoder turns its result code into the exception code the core must raise, along with a refill indication. Whenever a fault is reported and the core asserts the fault-valid strobe, the decoder captures three register images: the faulting address, a context word holding the page-pair number for the refill handler, and a translation-tag word whose address-space identifier byte survives the update.

Top module: `vseg_xlate`

## Requirements
- R1: For an address below 0x80000000 with erl_i low, tlb_req_o is high in every mode. With erl_i high, direct_o is high and pa_o equals the address.
- R2: For 0x80000000..0x9FFFFFFF in kernel mode (mode_i = 2'b00), direct_o is high and pa_o = address - 0x80000000. In any other mode, addr_err_o is high.
- R3: For 0xA0000000..0xBFFFFFFF in kernel mode, direct_o is high and pa_o = address - 0xA0000000. In any other mode, addr_err_o is high.
- R4: For 0xC0000000..0xDFFFFFFF, tlb_req_o is high in kernel or supervisor mode (mode_i = 2'b01). In user mode (2'b10) or in the reserved encoding 2'b11, which counts as user, addr_err_o is high.
- R5: For 0xE0000000..0xFFFFFFFF, tlb_req_o is high in kernel mode only, and addr_err_o is high otherwise. The error-level bit affects only addresses below 0x80000000.
- R6: Exactly one of direct_o, tlb_req_o and addr_err_o is high at any time, and pa_o is zero whenever direct_o is low.
- R7: An address error sets fault_o and gives exc_code_o = 4 for a read (wr_i = 0) or 5 for a write, with refill_o low.
- R8: On a TLB route, tlb_res_i = 2'b01 (no match) or 2'b10 (invalid entry) sets fault_o with code 2 for a read or 3 for a write. refill_o is high only for no match.
- R9: On a TLB route, tlb_res_i = 2'b11 (write to a clean page) gives code 1 for either direction, and 2'b00 (hit) gives fault_o low with code 0. tlb_res_i has no effect on a direct or address-error route.
- R10: On a clock edge where fault_vld_i and fault_o are both high, badvaddr_o takes the address.
- R11: On such an edge, context_o bits 22:4 take address bits 31:13, bits 3:0 become zero, and bits 31:23 are kept.
- R12: On such an edge, entryhi_o bits 31:13 take address bits 31:13, bits 12:8 become zero, and the identifier bits 7:0 are kept.
- R13: Reset loads the CTX_INIT and EHI_INIT parameter values and a zero address image. Without both the strobe and a fault, none of the three images change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| va_i | input | 32 | Virtual address |
| mode_i | input | 2 | Privilege: 00 kernel, 01 supervisor, 10 user, 11 treated as user |
| erl_i | input | 1 | Error-level bit |
| wr_i | input | 1 | 1 for a store, 0 for a load |
| direct_o | output | 1 | Address translated without lookup |
| pa_o | output | 32 | Direct physical address, zero otherwise |
| tlb_req_o | output | 1 | Request must go to the translation buffer |
| addr_err_o | output | 1 | Privilege violation |
| tlb_res_i | input | 2 | Lookup result: 00 hit, 01 no match, 10 invalid, 11 clean page written |
| fault_vld_i | input | 1 | Strobe allowing fault registers to update |
| fault_o | output | 1 | A fault is to be raised |
| exc_code_o | output | 5 | Exception code, 0 when no fault |
| refill_o | output | 1 | Fault was a lookup miss |
| badvaddr_o | output | 32 | Faulting address image |
| context_o | output | 32 | Context image |
| entryhi_o | output | 32 | Translation-tag image |

## Verification
The bench sweeps every mode, error-level value, direction and lookup result over the window boundary addresses and over scattered addresses. A decoder that compares the wrong number of top bits would misroute the first or last word of a window. One that applied the error-level bit outside the user window would drop TLB requests from kernel windows. Lookup results are also driven on direct and error routes, which catches a fault path that fails to gate them. With a non-zero reset image and the strobe toggled, the bench catches a context or tag update that clears the preserved bits, loses the identifier byte, or fires without the strobe.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

  localparam int VA_W = 32;
  localparam int EXC_W = 5;

  localparam logic [EXC_W-1:0] EXC_NONE  = 5'd0;
  localparam logic [EXC_W-1:0] EXC_MOD   = 5'd1;
  localparam logic [EXC_W-1:0] EXC_TLB_L = 5'd2;
  localparam logic [EXC_W-1:0] EXC_TLB_S = 5'd3;
  localparam logic [EXC_W-1:0] EXC_ADR_L = 5'd4;
  localparam logic [EXC_W-1:0] EXC_ADR_S = 5'd5;

  typedef enum logic [1:0] {
    MODE_KERN = 2'b00,
    MODE_SUPV = 2'b01,
    MODE_USER = 2'b10,
    MODE_RSVD = 2'b11
  } priv_mode_e;

  typedef enum logic [2:0] {
    SEG_USR = 3'd0,
    SEG_KD0 = 3'd1,
    SEG_KD1 = 3'd2,
    SEG_SUP = 3'd3,
    SEG_KM3 = 3'd4
  } vseg_e;

  typedef enum logic [1:0] {
    TLB_HIT   = 2'b00,
    TLB_MISS  = 2'b01,
    TLB_INVAL = 2'b10,
    TLB_CLEAN = 2'b11
  } tlb_res_e;

  // Window from the three top address bits.
  function automatic vseg_e seg_of(input logic [VA_W-1:0] va);
    if (!va[VA_W-1]) return SEG_USR;
    case (va[VA_W-2:VA_W-3])
      2'b00:   return SEG_KD0;
      2'b01:   return SEG_KD1;
      2'b10:   return SEG_SUP;
      default: return SEG_KM3;
    endcase
  endfunction

  function automatic logic seg_allowed(input vseg_e s, input priv_mode_e m);
    case (s)
      SEG_USR: return 1'b1;
      SEG_SUP: return (m == MODE_KERN) || (m == MODE_SUPV);
      default: return (m == MODE_KERN);
    endcase
  endfunction

  function automatic logic seg_mapped(input vseg_e s, input logic erl);
    case (s)
      SEG_USR: return !erl;
      SEG_KD0, SEG_KD1: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // Direct windows drop the three top bits; the user window passes through.
  function automatic logic [VA_W-1:0] direct_pa(input vseg_e s, input logic [VA_W-1:0] va);
    if (s == SEG_USR) return va;
    return {3'b000, va[VA_W-4:0]};
  endfunction

endpackage

// File: rtl/vseg_classify.sv
module vseg_classify
  import vseg_pkg::*;
(
  input  logic [VA_W-1:0] va_i,
  input  logic [1:0]      mode_i,
  input  logic            erl_i,
  output logic            direct_o,
  output logic            tlb_req_o,
  output logic            addr_err_o,
  output logic [VA_W-1:0] pa_o
);
  vseg_e      seg;
  priv_mode_e mode;
  logic       allowed;
  logic       mapped;

  always_comb begin
    mode       = priv_mode_e'(mode_i);
    seg        = seg_of(va_i);
    allowed    = seg_allowed(seg, mode);
    mapped     = seg_mapped(seg, erl_i);
    addr_err_o = !allowed;
    tlb_req_o  = allowed && mapped;
    direct_o   = allowed && !mapped;
    pa_o       = direct_o ? direct_pa(seg, va_i) : '0;
  end
endmodule

// File: rtl/vseg_fault_code.sv
module vseg_fault_code
  import vseg_pkg::*;
(
  input  logic             tlb_req_i,
  input  logic             addr_err_i,
  input  logic             wr_i,
  input  logic [1:0]       tlb_res_i,
  output logic             fault_o,
  output logic [EXC_W-1:0] code_o,
  output logic             refill_o
);
  tlb_res_e res;

  always_comb begin
    res      = tlb_res_e'(tlb_res_i);
    fault_o  = 1'b0;
    code_o   = EXC_NONE;
    refill_o = 1'b0;
    if (addr_err_i) begin
      fault_o = 1'b1;
      code_o  = wr_i ? EXC_ADR_S : EXC_ADR_L;
    end else if (tlb_req_i) begin
      case (res)
        TLB_MISS: begin
          fault_o  = 1'b1;
          refill_o = 1'b1;
          code_o   = wr_i ? EXC_TLB_S : EXC_TLB_L;
        end
        TLB_INVAL: begin
          fault_o = 1'b1;
          code_o  = wr_i ? EXC_TLB_S : EXC_TLB_L;
        end
        TLB_CLEAN: begin
          fault_o = 1'b1;
          code_o  = EXC_MOD;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vseg_fault_regs.sv
module vseg_fault_regs
  import vseg_pkg::*;
#(
  parameter int              ASID_W     = 8,
  parameter int              PAIR_SHIFT = 13,
  parameter int              CTX_LSB    = 4,
  parameter logic [VA_W-1:0] CTX_INIT   = '0,
  parameter logic [VA_W-1:0] EHI_INIT   = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture_i,
  input  logic [VA_W-1:0] va_i,
  output logic [VA_W-1:0] badvaddr_o,
  output logic [VA_W-1:0] context_o,
  output logic [VA_W-1:0] entryhi_o
);
  localparam int VPN_W   = VA_W - PAIR_SHIFT;
  localparam int CTX_MSB = CTX_LSB + VPN_W - 1;
  localparam int GAP_W   = PAIR_SHIFT - ASID_W;

  function automatic logic [VA_W-1:0] ctx_merge(input logic [VA_W-1:0] old,
                                                input logic [VA_W-1:0] va);
    logic [VA_W-1:0] n;
    n = old;
    n[CTX_MSB:CTX_LSB] = va[VA_W-1:PAIR_SHIFT];
    n[CTX_LSB-1:0]     = '0;
    return n;
  endfunction

  function automatic logic [VA_W-1:0] ehi_merge(input logic [VA_W-1:0] old,
                                                input logic [VA_W-1:0] va);
    return {va[VA_W-1:PAIR_SHIFT], {GAP_W{1'b0}}, old[ASID_W-1:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      badvaddr_o <= '0;
      context_o  <= CTX_INIT;
      entryhi_o  <= EHI_INIT;
    end else if (capture_i) begin
      badvaddr_o <= va_i;
      context_o  <= ctx_merge(context_o, va_i);
      entryhi_o  <= ehi_merge(entryhi_o, va_i);
    end
  end

  // R10
  badva_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> badvaddr_o == $past(va_i));
  // R13
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(badvaddr_o) && $stable(context_o) && $stable(entryhi_o));
  // R12
  asid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> $stable(entryhi_o[ASID_W-1:0]));
  // R11
  ctx_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> $stable(context_o[VA_W-1:CTX_MSB+1]));
endmodule

// File: rtl/vseg_xlate.sv
module vseg_xlate
  import vseg_pkg::*;
#(
  parameter int          ASID_W     = 8,
  parameter int          PAIR_SHIFT = 13,
  parameter int          CTX_LSB    = 4,
  parameter logic [31:0] CTX_INIT   = 32'h0000_0000,
  parameter logic [31:0] EHI_INIT   = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] va_i,
  input  logic [1:0]  mode_i,
  input  logic        erl_i,
  input  logic        wr_i,
  output logic        direct_o,
  output logic [31:0] pa_o,
  output logic        tlb_req_o,
  output logic        addr_err_o,
  input  logic [1:0]  tlb_res_i,
  input  logic        fault_vld_i,
  output logic        fault_o,
  output logic [4:0]  exc_code_o,
  output logic        refill_o,
  output logic [31:0] badvaddr_o,
  output logic [31:0] context_o,
  output logic [31:0] entryhi_o
);
  logic capture;

  vseg_classify u_classify (
    .va_i       (va_i),
    .mode_i     (mode_i),
    .erl_i      (erl_i),
    .direct_o   (direct_o),
    .tlb_req_o  (tlb_req_o),
    .addr_err_o (addr_err_o),
    .pa_o       (pa_o)
  );

  vseg_fault_code u_code (
    .tlb_req_i  (tlb_req_o),
    .addr_err_i (addr_err_o),
    .wr_i       (wr_i),
    .tlb_res_i  (tlb_res_i),
    .fault_o    (fault_o),
    .code_o     (exc_code_o),
    .refill_o   (refill_o)
  );

  assign capture = fault_vld_i && fault_o;

  vseg_fault_regs #(
    .ASID_W     (ASID_W),
    .PAIR_SHIFT (PAIR_SHIFT),
    .CTX_LSB    (CTX_LSB),
    .CTX_INIT   (CTX_INIT),
    .EHI_INIT   (EHI_INIT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_i  (capture),
    .va_i       (va_i),
    .badvaddr_o (badvaddr_o),
    .context_o  (context_o),
    .entryhi_o  (entryhi_o)
  );

  // R6
  one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({direct_o, tlb_req_o, addr_err_o}) == 1);
  // R7
  adr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_o |-> fault_o && !refill_o && (exc_code_o == (wr_i ? 5'd5 : 5'd4)));
  // R8
  refill_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_o |-> tlb_req_o && (exc_code_o == 5'd2 || exc_code_o == 5'd3));
  // R1
  erl_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erl_i && !va_i[31]) |-> direct_o && pa_o == va_i);
  // R9
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_o || (tlb_req_o && tlb_res_i == 2'b00)) |-> !fault_o && exc_code_o == 5'd0);
endmodule

// File: tb/vseg_xlate_bench.sv
`timescale 1ns/1ps
module vseg_xlate_bench;
  localparam logic [31:0] CTX0 = 32'hC380_0000;
  localparam logic [31:0] EHI0 = 32'h0000_00A7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] va = '0;
  logic [1:0]  mode = '0;
  logic        erl = 1'b0, wr = 1'b0, fvld = 1'b0;
  logic [1:0]  res = '0;
  logic        direct, tlbq, aerr, fault, refill;
  logic [31:0] pa, bad, ctx, ehi;
  logic [4:0]  code;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vseg_xlate #(.CTX_INIT(CTX0), .EHI_INIT(EHI0)) u_vseg_xlate (
    .clk(clk), .rst_n(rst_n), .va_i(va), .mode_i(mode), .erl_i(erl), .wr_i(wr),
    .direct_o(direct), .pa_o(pa), .tlb_req_o(tlbq), .addr_err_o(aerr),
    .tlb_res_i(res), .fault_vld_i(fvld), .fault_o(fault), .exc_code_o(code),
    .refill_o(refill), .badvaddr_o(bad), .context_o(ctx), .entryhi_o(ehi));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] addr_at(input int k);
    case (k)
      0: return 32'h0000_0000;  1: return 32'h7FFF_FFFF;
      2: return 32'h8000_0000;  3: return 32'h9FFF_FFFF;
      4: return 32'hA000_0000;  5: return 32'hBFFF_FFFF;
      6: return 32'hC000_0000;  7: return 32'hDFFF_FFFF;
      8: return 32'hE000_0000;  9: return 32'hFFFF_FFFF;
      default: return (32'h9E37_79B9 * k) ^ (k << 20) ^ 32'h0001_3F5C;
    endcase
  endfunction

  // Expected values from the address ranges, independent of the bit slicing in the design.
  logic [31:0] e_bad, e_ctx, e_ehi;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1..all act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int iter = 0;
    repeat (3) @(posedge clk);
    #1;
    // R13 reset images
    chk("R13", "reset bad", bad, 32'h0);
    chk("R13", "reset ctx", ctx, CTX0);
    chk("R13", "reset ehi", ehi, EHI0);
    @(negedge clk);
    rst_n = 1'b1;
    e_bad = 32'h0; e_ctx = CTX0; e_ehi = EHI0;
    for (int k = 0; k < 20; k++) begin
      for (int m = 0; m < 4; m++) begin
        for (int c = 0; c < 16; c++) begin
          logic kern, sup, x_dir, x_tlb, x_err, x_flt, x_ref;
          logic [31:0] x_pa;
          logic [4:0]  x_code;
          string rq;
          @(negedge clk);
          va = addr_at(k); mode = 2'(m);
          erl = c[0]; wr = c[1]; res = 2'(c >> 2);
          fvld = (iter % 3) != 0;
          iter++;
          kern = (m == 0); sup = (m == 1);
          x_dir = 0; x_tlb = 0; x_err = 0; x_pa = 0;
          if (va <= 32'h7FFF_FFFF) begin
            rq = "R1";
            if (erl) begin x_dir = 1; x_pa = va; end else x_tlb = 1;
          end else if (va < 32'hA000_0000) begin
            rq = "R2";
            if (kern) begin x_dir = 1; x_pa = va - 32'h8000_0000; end else x_err = 1;
          end else if (va < 32'hC000_0000) begin
            rq = "R3";
            if (kern) begin x_dir = 1; x_pa = va - 32'hA000_0000; end else x_err = 1;
          end else if (va < 32'hE000_0000) begin
            rq = "R4";
            if (kern || sup) x_tlb = 1; else x_err = 1;
          end else begin
            rq = "R5";
            if (kern) x_tlb = 1; else x_err = 1;
          end
          x_flt = 0; x_ref = 0; x_code = 0;
          if (x_err) begin x_flt = 1; x_code = wr ? 5 : 4; end
          else if (x_tlb && res == 2'b01) begin x_flt = 1; x_ref = 1; x_code = wr ? 3 : 2; end
          else if (x_tlb && res == 2'b10) begin x_flt = 1; x_code = wr ? 3 : 2; end
          else if (x_tlb && res == 2'b11) begin x_flt = 1; x_code = 1; end
          #1;
          chk(rq, "direct", 32'(direct), 32'(x_dir));
          chk(rq, "tlb_req", 32'(tlbq), 32'(x_tlb));
          chk(rq, "addr_err", 32'(aerr), 32'(x_err));
          chk("R6", "pa", pa, x_pa);
          chk(x_err ? "R7" : "R8", "fault", 32'(fault), 32'(x_flt));
          chk("R8", "refill", 32'(refill), 32'(x_ref));
          chk("R9", "code", 32'(code), 32'(x_code));
          if (fvld && x_flt) begin
            e_bad = va;
            e_ctx = (e_ctx & ~32'h007F_FFFF) | ((va >> 9) & 32'h007F_FFF0);
            e_ehi = (e_ehi & 32'h0000_00FF) | (va & ~32'h0000_1FFF);
          end
          @(posedge clk);
          #1;
          chk("R10", "badvaddr", bad, e_bad);
          chk("R11", "context", ctx, e_ctx);
          chk("R12", "entryhi", ehi, e_ehi);
        end
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule